// File: doc/BRIEF.md
# Receive Statistics Counter Bank with Threshold Interrupts

This block holds a bank of receive statistics counters, one per event class. The frame receiver pulses one event strobe per counter for one cycle each time that class of event occurs. Each counter is either wide (32 bits) or narrow (16 bits), as a per-counter parameter mask selects. A counter raises its own sticky status bit in two cases. The first is an increment that brings the count to the midpoint of its range. The second is an increment made while the count already holds all-ones.

A global rollover-stop input selects what a counter does on that second case. When the input is low, the counter wraps to zero. When it is high, the counter stays at all-ones.

Software reads a counter through a simple strobe-and-address port that has byte-lane enables. Only a counter read with the lowest lane enabled clears that counter's status bit. The status bits are visible as a 32-bit read-only word. A single interrupt line is the OR of all status bits.

Top module: `stat_irq_bank`

## Requirements
- R1: After reset every counter, every status bit and `irq` read 0. Each cycle that `evt[i]` is high, counter i increments by one.
- R2: The increment that makes a counter equal to 2^(W-1) sets status bit i. For a 16-bit counter that value is 0x8000, and for a 32-bit counter it is 0x8000_0000. With default parameters, counters 0 to 19 are 32-bit and counters 20 to 25 are 16-bit.
- R3: With `stop_roll` low, an increment of a counter holding all-ones wraps it to 0 and sets its status bit.
- R4: With `stop_roll` high, an increment of a counter holding all-ones leaves it at all-ones and still sets its status bit.
- R5: A read with `rd_en`=1, `rd_addr`=i and `rd_be[0]`=1 clears status bit i. The bit reads clear from the cycle after the read, provided no new crossing occurs in that same cycle.
- R6: A read of counter i with `rd_be[0]`=0 leaves status bit i set. `rd_be[k]` gates `rd_data[8k+7:8k]`, and any lane that is not enabled reads 0.
- R7: A status bit stays set until a qualifying read arrives. Further crossings while it is set, and observation of `int_status`, change nothing.
- R8: If a qualifying read and a threshold crossing of the same counter fall in the same cycle, the status bit ends set.
- R9: `rd_data` updates on the clock edge that samples `rd_en`. It holds the counter value from before any increment in that cycle, zero-extended to 32 bits. An address of NUM_CNT or above reads 0.
- R10: `int_status[i]` is status bit i for i below NUM_CNT, and the bits at and above NUM_CNT are 0. `irq` is high exactly when any status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt | input | NUM_CNT | Per-counter one-cycle increment strobes |
| stop_roll | input | 1 | 1: saturate at all-ones; 0: wrap to zero |
| rd_en | input | 1 | Counter read strobe |
| rd_addr | input | ADDR_W | Counter index to read |
| rd_be | input | 4 | Byte-lane enables for the read |
| rd_data | output | 32 | Registered read data |
| int_status | output | 32 | Read-only status word |
| irq | output | 1 | OR of all status bits |

## Verification
The hardest states to reach from the ports are the half-range and all-ones crossings, because only increments can get a counter there. The stimulus drives all six 16-bit counters together for 32768 and then 65535 strobes, which stays inside the cycle budget. The 32-bit counters share the same cell logic at a different width, so the bench checks them only at small counts. The read-versus-crossing collision needs a counter parked at all-ones with its bit already set. The bench gets there with saturation turned on, then issues the low-lane read and one more strobe in the same cycle.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int REG_W  = 32;
  localparam int LANE_W = 8;
  localparam int LANES  = REG_W / LANE_W;
  typedef logic [REG_W-1:0] word_t;
endpackage

// File: rtl/stat_cell.sv
// One statistics counter with its sticky threshold flag.
module stat_cell #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         stop_roll,
  input  logic         clr,
  output logic [W-1:0] cnt,
  output logic         flag
);
  localparam logic [W-1:0] HALF     = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] PRE_HALF = HALF - 1'b1;
  localparam logic [W-1:0] MAX      = '1;

  logic at_max, at_pre_half, hit;

  always_comb begin
    at_max      = (cnt == MAX);
    at_pre_half = (cnt == PRE_HALF);
    hit         = inc && (at_max || at_pre_half);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else begin
      if (inc) begin
        if (at_max) cnt <= stop_roll ? MAX : '0;
        else        cnt <= cnt + 1'b1;
      end
      // a new crossing wins over a clear in the same cycle
      flag <= hit | (flag & ~clr);
    end
  end

  a_r2_half_sets: assert property (@(posedge clk) disable iff (rst)
    (inc && cnt == PRE_HALF) |=> (flag && cnt == HALF));
  a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
    (inc && !stop_roll && cnt == MAX) |=> (cnt == '0 && flag));
  a_r4_saturate: assert property (@(posedge clk) disable iff (rst)
    (inc && stop_roll && cnt == MAX) |=> (cnt == MAX && flag));
  a_r5_clear: assert property (@(posedge clk) disable iff (rst)
    (clr && !inc) |=> !flag);
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);
endmodule

// File: rtl/stat_rd_port.sv
// Registered counter read mux with byte-lane gating.
module stat_rd_port
  import stat_pkg::*;
#(
  parameter int N  = 26,
  parameter int AW = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd_en,
  input  logic [AW-1:0]         rd_addr,
  input  logic [LANES-1:0]      rd_be,
  input  logic [N-1:0][REG_W-1:0] cnt_bus,
  output word_t                 rd_data
);
  word_t sel, lane_mask;

  always_comb begin
    sel = '0;
    for (int i = 0; i < N; i++)
      if (rd_addr == AW'(i)) sel = cnt_bus[i];
    for (int k = 0; k < LANES; k++)
      lane_mask[k*LANE_W +: LANE_W] = {LANE_W{rd_be[k]}};
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= sel & lane_mask;
  end

  a_r6_lane_gate: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !rd_be[0]) |=> (rd_data[LANE_W-1:0] == '0));
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/stat_irq_bank.sv
// Bank of receive statistics counters with clear-on-read status.
module stat_irq_bank
  import stat_pkg::*;
#(
  parameter int             NUM_CNT   = 26,
  parameter int             WIDE_W    = 32,
  parameter int             NARROW_W  = 16,
  parameter logic [NUM_CNT-1:0] WIDE_MASK = 26'h00F_FFFF,
  localparam int            ADDR_W    = $clog2(NUM_CNT)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CNT-1:0] evt,
  input  logic               stop_roll,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic [LANES-1:0]   rd_be,
  output logic [REG_W-1:0]   rd_data,
  output logic [REG_W-1:0]   int_status,
  output logic               irq
);
  logic [NUM_CNT-1:0]            flags;
  logic [NUM_CNT-1:0]            clr;
  logic [NUM_CNT-1:0][REG_W-1:0] cnt_bus;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    localparam int CW = WIDE_MASK[i] ? WIDE_W : NARROW_W;
    logic [CW-1:0] value;

    assign clr[i] = rd_en && rd_be[0] && (rd_addr == ADDR_W'(i));

    stat_cell #(.W(CW)) u_cell (
      .clk      (clk),
      .rst      (rst),
      .inc      (evt[i]),
      .stop_roll(stop_roll),
      .clr      (clr[i]),
      .cnt      (value),
      .flag     (flags[i])
    );

    assign cnt_bus[i] = REG_W'(value);
  end

  stat_rd_port #(.N(NUM_CNT), .AW(ADDR_W)) u_rd (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (rd_en),
    .rd_addr(rd_addr),
    .rd_be  (rd_be),
    .cnt_bus(cnt_bus),
    .rd_data(rd_data)
  );

  always_comb begin
    int_status                = '0;
    int_status[NUM_CNT-1:0]   = flags;
    irq                       = |flags;
  end

  a_r10_irq_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(evt) != '0));
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (int_status == '0));
endmodule

// File: tb/sim_stat_irq_bank.sv
`timescale 1ns/1ps
module sim_stat_irq_bank;
  localparam int N = 26;

  logic        clk = 1'b0;
  logic        rst;
  logic [N-1:0] evt;
  logic        stop_roll, rd_en;
  logic [4:0]  rd_addr;
  logic [3:0]  rd_be;
  logic [31:0] rd_data, int_status;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  stat_irq_bank u0 (
    .clk(clk), .rst(rst), .evt(evt), .stop_roll(stop_roll),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_be(rd_be),
    .rd_data(rd_data), .int_status(int_status), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(logic [N-1:0] m, int n);
    for (int c = 0; c < n; c++) begin
      evt = m;
      @(negedge clk);
    end
    evt = '0;
  endtask

  task automatic rd(logic [4:0] a, logic [3:0] be);
    rd_en = 1'b1; rd_addr = a; rd_be = be;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // {index, increments, byte enables, expected read data}
  localparam logic [56:0] VEC [6] = '{
    {5'd0,  16'd1,   4'hF, 32'h0000_0001},
    {5'd3,  16'd5,   4'h1, 32'h0000_0005},
    {5'd7,  16'd300, 4'h2, 32'h0000_0100},
    {5'd8,  16'd300, 4'h1, 32'h0000_002C},
    {5'd12, 16'd258, 4'hF, 32'h0000_0102},
    {5'd19, 16'd255, 4'hC, 32'h0000_0000}
  };

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] narrow;
    narrow = 26'h3F0_0000;
    rst = 1'b1; evt = '0; stop_roll = 1'b0;
    rd_en = 1'b0; rd_addr = '0; rd_be = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 status", int_status, 32'h0);
    check("R1 irq", {31'd0, irq}, 32'h0);
    rd(5'd0, 4'hF);
    check("R1 count", rd_data, 32'h0);

    // R1/R6 table walk on 32-bit counters
    foreach (VEC[v]) begin
      pulse(N'(1) << VEC[v][56:52], int'(VEC[v][51:36]));
      rd(VEC[v][56:52], VEC[v][35:32]);
      check("R6 table read", rd_data, VEC[v][31:0]);
      check("R7 table status", int_status, 32'h0);
    end

    // R2 half range on 16-bit counters
    pulse(narrow, 32767);
    check("R2 below half", int_status, 32'h0);
    pulse(narrow, 1);
    check("R2 half set", int_status, 32'h03F0_0000);
    check("R10 irq", {31'd0, irq}, 32'h1);
    // R6 upper lanes only
    rd(5'd20, 4'hE);
    check("R6 upper read", rd_data, 32'h0000_8000);
    check("R6 bit kept", int_status, 32'h03F0_0000);
    // R5 low lane clears
    rd(5'd20, 4'h1);
    check("R5 low read", rd_data, 32'h0);
    check("R5 cleared", int_status, 32'h03E0_0000);
    for (int a = 21; a < 26; a++) rd(5'(a), 4'hF);
    check("R5 all cleared", int_status, 32'h0);

    // up to all-ones
    pulse(narrow, 32767);
    check("R7 no flag at max", int_status, 32'h0);
    // R4 saturation
    stop_roll = 1'b1;
    pulse(N'(1) << 21, 1);
    check("R4 flag", int_status, 32'h0020_0000);
    rd(5'd21, 4'hF);
    check("R4 held", rd_data, 32'h0000_FFFF);
    // R3 wrap
    stop_roll = 1'b0;
    pulse(N'(1) << 20, 1);
    check("R3 flag", int_status, 32'h0010_0000);
    rd(5'd20, 4'hF);
    check("R3 wrapped", rd_data, 32'h0);
    // R8 collision
    stop_roll = 1'b1;
    pulse(N'(1) << 23, 1);
    check("R8 pre set", int_status[23], 1'b1);
    evt = N'(1) << 23;
    rd(5'd23, 4'h1);
    evt = '0;
    check("R8 data", rd_data, 32'h0000_00FF);
    check("R8 kept", int_status[23], 1'b1);
    rd(5'd23, 4'h1);
    check("R8 later clear", int_status[23], 1'b0);
    // R9 pre-increment value
    stop_roll = 1'b0;
    evt = N'(1) << 24;
    rd(5'd24, 4'hF);
    evt = '0;
    check("R9 old value", rd_data, 32'h0000_FFFF);
    rd(5'd24, 4'hF);
    check("R9 new value", rd_data, 32'h0);
    rd(5'd30, 4'hF);
    check("R9 bad addr", rd_data, 32'h0);
    check("R10 all clear", int_status, 32'h0);
    check("R10 irq low", {31'd0, irq}, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule